// File: doc/BRIEF.md
# Prioritized Exception Cause Selector

This block takes the sixteen pending-exception flags raised for one instruction and reduces them to a single answer: whether any exception is pending, and the 4-bit cause number of the one that wins. The winner is chosen by a fixed ranking, not by the lowest index. Breakpoints and instruction-fetch faults come first. Environment calls follow. Memory faults come last, and within each fault kind a store fault beats a load fault.

Two filters are applied before the ranking. A scope select either narrows the candidates to the four causes an instruction-fetch stage can raise, or admits all fourteen defined causes. Codes 10 and 14 are reserved and are never admitted. A per-unit enable mask then keeps only the causes that the issuing execution unit is allowed to raise. The result is registered, so it appears one cycle after the request.

Top module: `exc_cause_sel`

## Requirements
- R1: Among the admitted flags, the reported cause is the one ranked highest in the order 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5 (first is highest). Cause codes are the bit indices of `exc_vec`.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R3: `has_exc` is 1 exactly when at least one flag survives filtering and `in_valid` was 1. When `has_exc` is 0, `cause` is 0.
- R4: When `sel_frontend` is 1, only bits 0, 1, 2 and 12 of `exc_vec` are candidates. All other bits are ignored.
- R5: When `sel_frontend` is 0, bits 10 and 14 of `exc_vec` are ignored and can never be reported.
- R6: A flag whose bit in `unit_mask` is 0 is ignored. The unit mask is applied on top of the scope filter.
- R7: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and `has_exc` and sets `cause` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier for this cycle |
| exc_vec | input | 16 | Pending exception flags, bit index = cause code |
| sel_frontend | input | 1 | 1: fetch-stage causes only; 0: all defined causes |
| unit_mask | input | 16 | Causes the issuing unit may raise |
| out_valid | output | 1 | Registered copy of in_valid |
| has_exc | output | 1 | An exception survived filtering |
| cause | output | 4 | Winning cause code, 0 when none |

## Verification
The ranking is tested by stripping the current winner from the vector step by step. This walks down the order one place at a time and shows any adjacent pair that has been swapped, including the store-over-load pairs. Vectors that contain only reserved bits, or only causes outside the fetch set, show that each filter actually removes bits rather than merely lowering their rank. Unit-mask patterns that hide the natural winner show that the mask is applied before the ranking, not after it. Vectors presented with `in_valid` low, and a reset asserted during a stream of requests, show the qualifying and clearing behaviour.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int EXC_W    = 16;
    localparam int CAUSE_W  = $clog2(EXC_W);
    localparam int NUM_RANK = 14;

    typedef logic [EXC_W-1:0]   exc_vec_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef struct packed {
        logic   valid;
        logic   has;
        cause_t cause;
    } sel_out_t;

    // Rank 0 is the highest priority.
    function automatic cause_t rank_to_cause(input int r);
        cause_t c;
        case (r)
            0:       c = 4'd3;   // breakpoint
            1:       c = 4'd12;  // fetch page fault
            2:       c = 4'd1;   // fetch access fault
            3:       c = 4'd2;   // illegal instruction
            4:       c = 4'd0;   // fetch misaligned
            5:       c = 4'd11;  // environment call, M
            6:       c = 4'd9;   // environment call, S
            7:       c = 4'd8;   // environment call, U
            8:       c = 4'd6;   // store misaligned
            9:       c = 4'd4;   // load misaligned
            10:      c = 4'd15;  // store page fault
            11:      c = 4'd13;  // load page fault
            12:      c = 4'd7;   // store access fault
            default: c = 4'd5;   // load access fault
        endcase
        return c;
    endfunction

    // Every ranked cause is admitted; the unranked (reserved) codes are not.
    function automatic exc_vec_t full_keep();
        exc_vec_t k;
        k = '0;
        for (int r = 0; r < NUM_RANK; r++) k[rank_to_cause(r)] = 1'b1;
        return k;
    endfunction

    function automatic exc_vec_t fetch_keep();
        exc_vec_t k;
        k = '0;
        k[0]  = 1'b1;
        k[1]  = 1'b1;
        k[2]  = 1'b1;
        k[12] = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/exc_cause_filter.sv
module exc_cause_filter
    import exc_sel_pkg::*;
(
    input  logic     sel_frontend,
    input  exc_vec_t raw_vec,
    input  exc_vec_t unit_mask,
    output exc_vec_t kept_vec
);
    localparam exc_vec_t FULL_KEEP  = full_keep();
    localparam exc_vec_t FETCH_KEEP = fetch_keep();

    exc_vec_t scope_keep;

    always_comb begin
        scope_keep = sel_frontend ? FETCH_KEEP : FULL_KEEP;
        kept_vec   = raw_vec & scope_keep & unit_mask;
    end
endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
    import exc_sel_pkg::*;
(
    input  exc_vec_t kept_vec,
    output logic     any_hit,
    output cause_t   win_cause
);
    logic [NUM_RANK-1:0] rank_hit;

    for (genvar r = 0; r < NUM_RANK; r++) begin : g_rank
        assign rank_hit[r] = kept_vec[rank_to_cause(r)];
    end

    always_comb begin
        any_hit   = |rank_hit;
        win_cause = '0;
        for (int r = NUM_RANK - 1; r >= 0; r--) begin
            if (rank_hit[r]) win_cause = rank_to_cause(r);
        end
    end
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_sel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] exc_vec,
    input  logic        sel_frontend,
    input  logic [15:0] unit_mask,
    output logic        out_valid,
    output logic        has_exc,
    output logic [3:0]  cause
);
    exc_vec_t kept_vec;
    logic     any_hit;
    cause_t   win_cause;
    sel_out_t out_d, out_q;

    exc_cause_filter u_filter (
        .sel_frontend (sel_frontend),
        .raw_vec      (exc_vec),
        .unit_mask    (unit_mask),
        .kept_vec     (kept_vec)
    );

    exc_rank_pick u_pick (
        .kept_vec  (kept_vec),
        .any_hit   (any_hit),
        .win_cause (win_cause)
    );

    always_comb begin
        out_d.valid = in_valid;
        out_d.has   = in_valid & any_hit;
        out_d.cause = (in_valid & any_hit) ? win_cause : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign has_exc   = out_q.has;
    assign cause     = out_q.cause;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !has_exc));
    p_zero_cause_r3: assert property (@(posedge clk) disable iff (rst)
        !has_exc |-> (cause == 4'd0));
    p_no_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        has_exc |-> (cause != 4'd10 && cause != 4'd14));
    p_fetch_scope_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel_frontend) |=>
            (!has_exc || cause == 4'd0 || cause == 4'd1 || cause == 4'd2 || cause == 4'd12));
    p_unit_owned_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!has_exc || ((($past(unit_mask) >> cause) & 16'd1) != 16'd0)));
    p_flag_source_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!has_exc || ((($past(exc_vec) >> cause) & 16'd1) != 16'd0)));
endmodule

// File: tb/sim_exc_cause_sel.sv
`timescale 1ns/1ps
module sim_exc_cause_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] exc_vec = '0;
    logic        sel_frontend = 1'b0;
    logic [15:0] unit_mask = '0;
    logic        out_valid, has_exc;
    logic [3:0]  cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    exc_cause_sel u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .exc_vec(exc_vec),
        .sel_frontend(sel_frontend), .unit_mask(unit_mask),
        .out_valid(out_valid), .has_exc(has_exc), .cause(cause)
    );

    // {exc_vec, sel_frontend, unit_mask, exp_has, exp_cause}
    localparam int NV = 19;
    localparam logic [37:0] TBL [0:NV-1] = '{
        {16'h0000, 1'b0, 16'hFFFF, 1'b0, 4'd0 },  // R3 nothing pending
        {16'hFFFF, 1'b0, 16'hFFFF, 1'b1, 4'd3 },  // R1 breakpoint beats all
        {16'hFFF7, 1'b0, 16'hFFFF, 1'b1, 4'd12},  // R1
        {16'h0007, 1'b0, 16'hFFFF, 1'b1, 4'd1 },  // R1
        {16'h0005, 1'b0, 16'hFFFF, 1'b1, 4'd2 },  // R1
        {16'h0B00, 1'b0, 16'hFFFF, 1'b1, 4'd11},  // R1
        {16'h0300, 1'b0, 16'hFFFF, 1'b1, 4'd9 },  // R1
        {16'h0050, 1'b0, 16'hFFFF, 1'b1, 4'd6 },  // R1 store over load
        {16'hA0A0, 1'b0, 16'hFFFF, 1'b1, 4'd15},  // R1
        {16'h20A0, 1'b0, 16'hFFFF, 1'b1, 4'd13},  // R1
        {16'h00A0, 1'b0, 16'hFFFF, 1'b1, 4'd7 },  // R1
        {16'h0020, 1'b0, 16'hFFFF, 1'b1, 4'd5 },  // R1
        {16'h4400, 1'b0, 16'hFFFF, 1'b0, 4'd0 },  // R5 reserved only
        {16'h4410, 1'b0, 16'hFFFF, 1'b1, 4'd4 },  // R5
        {16'h1008, 1'b1, 16'hFFFF, 1'b1, 4'd12},  // R4 breakpoint out of scope
        {16'hEEF8, 1'b1, 16'hFFFF, 1'b0, 4'd0 },  // R4 nothing in fetch set
        {16'h1009, 1'b0, 16'h0001, 1'b1, 4'd0 },  // R6 mask hides winners
        {16'h0008, 1'b0, 16'hFFF7, 1'b0, 4'd0 },  // R6
        {16'h1006, 1'b1, 16'h0004, 1'b1, 4'd2 }   // R4 R6 combined
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got has/cause=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic check_valid(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: out_valid=%b exp=%b", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, exp completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check_valid("R7 reset out_valid", out_valid, 1'b0);
        check("R7 reset outputs", {has_exc, cause}, 5'b0);
        rst = 1'b0;

        // Table walk: drive row i, sample one edge later.
        for (int i = 0; i < NV; i++) begin
            exc_vec      = TBL[i][37:22];
            sel_frontend = TBL[i][21];
            unit_mask    = TBL[i][20:5];
            in_valid     = 1'b1;
            @(negedge clk);
            check_valid("R2 valid follows", out_valid, 1'b1);
            check($sformatf("R1/R3-R6 row %0d", i), {has_exc, cause}, TBL[i][4:0]);
        end

        // R2/R3: in_valid low with flags present
        in_valid = 1'b0; exc_vec = 16'hFFFF; sel_frontend = 1'b0; unit_mask = 16'hFFFF;
        @(negedge clk);
        check_valid("R2 invalid request", out_valid, 1'b0);
        check("R3 invalid request", {has_exc, cause}, 5'b0);

        // R7: reset in the middle of a request stream
        in_valid = 1'b1; exc_vec = 16'h0020;
        @(negedge clk);
        check("R1 pre-reset", {has_exc, cause}, {1'b1, 4'd5});
        rst = 1'b1;
        @(negedge clk);
        check_valid("R7 mid-stream reset", out_valid, 1'b0);
        check("R7 mid-stream reset", {has_exc, cause}, 5'b0);
        rst = 1'b0;
        @(negedge clk);
        check_valid("R2 after reset", out_valid, 1'b1);
        check("R1 after reset", {has_exc, cause}, {1'b1, 4'd5});

        // R5: each reserved bit alone
        exc_vec = 16'h0400;
        @(negedge clk);
        check("R5 bit 10 alone", {has_exc, cause}, 5'b0);
        exc_vec = 16'h4000;
        @(negedge clk);
        check("R5 bit 14 alone", {has_exc, cause}, 5'b0);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule